// File: doc/BRIEF.md
# Bitwise Identifier Arbitration Unit

This unit decides, one bit period at a time, whether this node owns a shared open-drain bus. The bus is wired-AND: a driven 0 (dominant) overrides any 1 (recessive). A frame on the bus opens with a dominant start bit, followed by an 11-bit identifier. The identifier is sent most significant bit first, and the lowest identifier on the bus prevails without destroying anyone's bits. When the unit has a request pending and the bus has gone quiet, it drives the start bit and then its identifier. At every bit sample it compares the level it drives with the level it reads back.

A node that drove recessive but reads dominant has been outbid. It stops at once, releases the bus for the rest of the frame and tries again at the next idle period. A node that reaches the end of the identifier with no mismatch has won, and reports this until the requester drops its request. The control field, data, CRC and the rest of the frame are sent by the surrounding logic. A readback of recessive while driving dominant cannot come from arbitration, so it is reported as a bit error. Bit timing comes from outside: a one-cycle `bit_tick` strobe marks each sample point.

The controller has five states. WAIT_IDLE counts recessive samples. IDLE means the bus is free. SOF drives the start bit. ARB drives the identifier. WON holds the win. Its transitions are:
- idle-found: WAIT_IDLE to IDLE on the 11th consecutive recessive sample.
- foreign-start: IDLE to WAIT_IDLE when a dominant bit is sampled in IDLE.
- launch: IDLE to SOF when a request is present.
- sof-ok: SOF to ARB when the start bit reads back dominant.
- sof-error: SOF to WAIT_IDLE when the start bit reads back recessive.
- outbid: ARB to WAIT_IDLE when arbitration is lost.
- arb-error: ARB to WAIT_IDLE on a bit error.
- win: ARB to WON after the last identifier bit is sampled cleanly.
- release: WON to WAIT_IDLE when the request drops.

Top module: `arb_unit`

## Requirements
- R1: After reset `bus_tx` is 1 (recessive) and `arb_won`, `arb_lost` and `bit_err` are 0.
- R2: The bus counts as idle only after 11 consecutive samples (clock edges with `bit_tick` = 1) read `bus_rx` = 1. Any sample reading 0 restarts the count, and `bus_tx` stays 1 until the count completes.
- R3: Once the bus is idle, `bus_tx` goes to 0 (start bit) on the clock after `tx_req` is seen high. The unit never leaves the recessive level without a request.
- R4: After the start bit, the unit drives one identifier bit per sample period, starting with bit 10 and ending with bit 0. Each bit is held on `bus_tx` until the sample that ends its period.
- R5: If a sample reads `bus_rx` = 0 while `bus_tx` = 1 during the identifier, `arb_lost` is 1 for exactly the clock cycle after that sample, and `bus_tx` is 1 from that same cycle on.
- R6: After a loss, `bus_tx` stays 1 for the rest of the foreign frame. With the request still high, a new start bit is driven only after a fresh count of 11 recessive samples.
- R7: When bit 0 is sampled without a mismatch, `arb_won` rises on the clock after that sample and stays 1, with `bus_tx` = 1, until `tx_req` falls. It returns to 0 on the clock after `tx_req` falls.
- R8: A sample reading `bus_rx` = 1 while `bus_tx` = 0, whether in the start bit or the identifier, pulses `bit_err` for one cycle instead of `arb_lost`. The unit then waits for idle again.
- R9: The identifier is captured when the start bit is launched. Changes on `tx_id` during the frame have no effect on the bits driven or on the outcome.
- R10: At most one of `arb_won`, `arb_lost` and `bit_err` is 1 in any cycle.
- R11: A dominant sample while the unit is idle with no request means another node has started a frame. A request raised afterwards waits for a new run of 11 recessive samples.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_tick | input | 1 | One-cycle strobe marking a bit sample point |
| bus_rx | input | 1 | Level read back from the wired-AND bus |
| tx_req | input | 1 | A message is pending |
| tx_id | input | ID_W | Identifier of the pending message |
| bus_tx | output | 1 | Level driven onto the bus (0 dominant) |
| arb_won | output | 1 | Arbitration won; held until request drops |
| arb_lost | output | 1 | One-cycle pulse: outbid by another node |
| bit_err | output | 1 | One-cycle pulse: dominant drive read back recessive |

## Verification
The hardest cases to reach from the ports are the mismatch cases, because they only arise when two transmitters overlap. The bench contains a second, behavioural node that arbitrates bit for bit, and builds `bus_rx` as the wired-AND of that node and `bus_tx`. Choosing identifier pairs that first differ at bit 10, at bit 8 or at bit 1 places the loss at different sample periods. The mismatch in the other direction (driving dominant, reading recessive) cannot occur on a real wired-AND. A forcing term in the bench's bus model pulls the line recessive in one chosen slot to reach it. Idle-count resets and the foreign-start rule are exercised with partial recessive runs broken by a single dominant slot. The request is held high throughout, so any early start shows up at once on `bus_tx`.

// File: rtl/arb_pkg.sv
package arb_pkg;

    typedef enum logic [2:0] {
        ST_WAIT_IDLE = 3'd0,
        ST_IDLE      = 3'd1,
        ST_SOF       = 3'd2,
        ST_ARB       = 3'd3,
        ST_WON       = 3'd4
    } arb_state_e;

    localparam logic LVL_DOMINANT  = 1'b0;
    localparam logic LVL_RECESSIVE = 1'b1;

endpackage

// File: rtl/arb_idle_counter.sv
module arb_idle_counter #(
    parameter int RUN_LEN = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic sample,
    input  logic level,
    output logic run_done
);
    localparam int CNT_W = $clog2(RUN_LEN + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(RUN_LEN - 1);

    logic [CNT_W-1:0] run_q;

    assign run_done = enable && sample && level && (run_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (!enable || run_done) begin
            run_q <= '0;
        end else if (sample) begin
            run_q <= level ? run_q + 1'b1 : '0;
        end
    end
endmodule

// File: rtl/arb_bit_compare.sv
module arb_bit_compare (
    input  logic active,
    input  logic sample,
    input  logic driven,
    input  logic seen,
    output logic outbid,
    output logic mismatch_err
);
    assign outbid       = active && sample && driven && !seen;
    assign mismatch_err = active && sample && !driven && seen;
endmodule

// File: rtl/arb_unit.sv
module arb_unit #(
    parameter int ID_W      = 11,
    parameter int IDLE_BITS = 11
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bit_tick,
    input  logic            bus_rx,
    input  logic            tx_req,
    input  logic [ID_W-1:0] tx_id,
    output logic            bus_tx,
    output logic            arb_won,
    output logic            arb_lost,
    output logic            bit_err
);
    import arb_pkg::*;

    localparam int IDX_W = (ID_W > 1) ? $clog2(ID_W) : 1;
    localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(ID_W - 1);

    arb_state_e      state_q, state_d;
    logic [ID_W-1:0]  id_q;
    logic [IDX_W-1:0] idx_q;
    logic            lost_q, err_q;
    logic            idle_found, cmp_outbid, cmp_err, comparing;

    arb_idle_counter #(.RUN_LEN(IDLE_BITS)) u_idle (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (state_q == ST_WAIT_IDLE),
        .sample   (bit_tick),
        .level    (bus_rx),
        .run_done (idle_found)
    );

    assign comparing = (state_q == ST_SOF) || (state_q == ST_ARB);

    arb_bit_compare u_cmp (
        .active       (comparing),
        .sample       (bit_tick),
        .driven       (bus_tx),
        .seen         (bus_rx),
        .outbid       (cmp_outbid),
        .mismatch_err (cmp_err)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT_IDLE: if (idle_found) state_d = ST_IDLE;
            ST_IDLE: begin
                if (bit_tick && !bus_rx) state_d = ST_WAIT_IDLE;
                else if (tx_req)         state_d = ST_SOF;
            end
            ST_SOF: begin
                if (cmp_err)       state_d = ST_WAIT_IDLE;
                else if (bit_tick) state_d = ST_ARB;
            end
            ST_ARB: begin
                if (cmp_outbid || cmp_err)       state_d = ST_WAIT_IDLE;
                else if (bit_tick && idx_q == '0) state_d = ST_WON;
            end
            ST_WON: if (!tx_req) state_d = ST_WAIT_IDLE;
            default: state_d = ST_WAIT_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_WAIT_IDLE;
            id_q    <= '0;
            idx_q   <= '0;
            lost_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            lost_q  <= (state_q == ST_ARB) && cmp_outbid;
            err_q   <= cmp_err;
            if (state_q == ST_IDLE && state_d == ST_SOF) begin
                id_q  <= tx_id;
                idx_q <= IDX_TOP;
            end else if (state_q == ST_ARB && bit_tick && idx_q != '0) begin
                idx_q <= idx_q - 1'b1;
            end
        end
    end

    always_comb begin
        bus_tx  = LVL_RECESSIVE;
        arb_won = 1'b0;
        unique case (state_q)
            ST_SOF:  bus_tx = LVL_DOMINANT;
            ST_ARB:  bus_tx = id_q[idx_q];
            ST_WON:  arb_won = 1'b1;
            default: bus_tx = LVL_RECESSIVE;
        endcase
        arb_lost = lost_q;
        bit_err  = err_q;
    end
endmodule

module arb_unit_chk (
    input logic               clk,
    input logic               rst_n,
    input logic               bit_tick,
    input logic               bus_rx,
    input logic               tx_req,
    input logic               bus_tx,
    input logic               arb_won,
    input logic               arb_lost,
    input logic               bit_err,
    input arb_pkg::arb_state_e state
);
    import arb_pkg::*;

    AST_LOST_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        arb_lost |-> ($past(bit_tick) && $past(bus_tx) && !$past(bus_rx))); // R5
    AST_LOST_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        arb_lost |-> bus_tx); // R5
    AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        bit_err |-> ($past(bit_tick) && !$past(bus_tx) && $past(bus_rx))); // R8
    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({arb_won, arb_lost, bit_err})); // R10
    AST_WON_RECESSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        arb_won |-> bus_tx); // R7
    AST_LAUNCH_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SOF && $past(state) != ST_SOF) |-> ($past(state) == ST_IDLE && $past(tx_req))); // R3
    AST_TICK_PACED: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_tick && state != ST_IDLE && state != ST_WON) |=> $stable(state)); // R4
endmodule

bind arb_unit arb_unit_chk u_arb_unit_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_tick (bit_tick),
    .bus_rx   (bus_rx),
    .tx_req   (tx_req),
    .bus_tx   (bus_tx),
    .arb_won  (arb_won),
    .arb_lost (arb_lost),
    .bit_err  (bit_err),
    .state    (state_q)
);

// File: tb/test_arb_unit.sv
`timescale 1ns/1ps
module test_arb_unit;
    localparam int ID_W = 11;
    localparam int K_WON = 1, K_LOST = 2, K_ERR = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bit_tick = 1'b0;
    logic            tx_req = 1'b0;
    logic [ID_W-1:0] tx_id = '0;
    logic            other_tx = 1'b1;
    logic            force_rec = 1'b0;
    logic            bus_rx, bus_tx, arb_won, arb_lost, bit_err;

    int checks = 0;
    int fails  = 0;
    int exp_q[$];
    logic done = 1'b0;

    always #10 clk = ~clk;

    assign bus_rx = force_rec | (bus_tx & other_tx);

    arb_unit #(.ID_W(ID_W), .IDLE_BITS(11)) i_arb_unit (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .bus_rx(bus_rx),
        .tx_req(tx_req), .tx_id(tx_id), .bus_tx(bus_tx), .arb_won(arb_won),
        .arb_lost(arb_lost), .bit_err(bit_err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_tick();
        @(negedge clk) bit_tick = 1'b1;
        @(negedge clk) bit_tick = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    // Monitor: turns port activity into {kind, sample index since start bit}
    logic in_frame = 1'b0;
    int   ticks = 0;
    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            if (in_frame && bit_tick) ticks++;
            if (arb_lost || bit_err || (arb_won && in_frame)) begin
                int act, expv;
                act = (arb_won ? K_WON : arb_lost ? K_LOST : K_ERR) * 100 + ticks;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5/R7/R8 unexpected outcome", act, 0);
                end else begin
                    expv = exp_q.pop_front();
                    check(act == expv, "R5/R7/R8 outcome kind*100+sample", act, expv);
                end
                in_frame = 1'b0;
            end else if (!in_frame && !bus_tx) begin
                in_frame = 1'b1;
                ticks = 0;
            end
        end
    end

    // Driver: 11 recessive samples, then one frame against an optional rival
    task automatic frame(input logic [ID_W-1:0] myid, input bit oth_on,
                         input logic [ID_W-1:0] othid, input int err_slot,
                         input bit swap, input logic [ID_W-1:0] swap_id);
        int kind, etick, p;
        bit oth_stop;
        tx_id = myid; tx_req = 1'b1; other_tx = 1'b1; force_rec = 1'b0;
        for (int i = 0; i < 11; i++) begin
            do_tick();
            if (i < 10) check(bus_tx == 1'b1, "R2 no start before 11 recessive", bus_tx, 1);
        end
        kind = K_WON; etick = 12;
        if (err_slot >= 0) begin
            kind = K_ERR; etick = err_slot + 1;
        end else if (oth_on && myid > othid) begin
            p = ID_W - 1;
            while (myid[p] == othid[p]) p--;
            kind = K_LOST; etick = 12 - p;
        end
        exp_q.push_back(kind * 100 + etick);
        oth_stop = 1'b0;
        for (int s = 0; s < etick; s++) begin
            logic mybit, obit;
            mybit = (s == 0) ? 1'b0 : myid[ID_W - s];
            obit  = (oth_on && !oth_stop) ? ((s == 0) ? 1'b0 : othid[ID_W - s]) : 1'b1;
            other_tx  = obit;
            force_rec = (s == err_slot);
            if (swap && s == 1) tx_id = swap_id;
            check(bus_tx == mybit, "R4 driven bit (slot 0 = R3 start bit)", bus_tx, mybit);
            do_tick();
            if (obit && !mybit) oth_stop = 1'b1;
        end
        other_tx = 1'b1; force_rec = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(bus_tx == 1'b1, "R1 bus_tx after reset", bus_tx, 1);
        check({arb_won, arb_lost, bit_err} == 3'b000, "R1 flags after reset",
              {arb_won, arb_lost, bit_err}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Solo win, then release
        frame(11'h5A3, 1'b0, '0, -1, 1'b0, '0);
        check(arb_won == 1'b1 && bus_tx == 1'b1, "R7 won held, bus recessive", arb_won, 1);
        repeat (5) @(negedge clk);
        check(arb_won == 1'b1, "R7 won held while request high", arb_won, 1);
        tx_req = 1'b0;
        @(negedge clk);
        check(arb_won == 1'b0, "R7 won drops after request", arb_won, 0);

        // No request: idle bus never driven
        for (int i = 0; i < 14; i++) do_tick();
        check(bus_tx == 1'b1, "R3 no start without request", bus_tx, 1);

        // R11: foreign start while idle, then request
        other_tx = 1'b0; do_tick(); other_tx = 1'b1;
        frame(11'h001, 1'b0, '0, -1, 1'b0, '0);
        tx_req = 1'b0; repeat (2) @(negedge clk);

        // R2: broken recessive run restarts count
        tx_req = 1'b1; tx_id = 11'h002;
        for (int i = 0; i < 6; i++) do_tick();
        other_tx = 1'b0; do_tick(); other_tx = 1'b1;
        check(bus_tx == 1'b1, "R2 dominant restarts idle count", bus_tx, 1);
        frame(11'h002, 1'b0, '0, -1, 1'b0, '0);
        tx_req = 1'b0; repeat (2) @(negedge clk);

        // Contest won against rival (rival loses at bit 10)
        frame(11'h0F0, 1'b1, 11'h400, -1, 1'b0, '0);
        tx_req = 1'b0; repeat (2) @(negedge clk);

        // Loss late (bit 1), foreign frame continues, then retry
        frame(11'h123, 1'b1, 11'h120, -1, 1'b0, '0);
        for (int i = 0; i < 4; i++) begin
            other_tx = 1'b0; do_tick();
            check(bus_tx == 1'b1, "R6 recessive during foreign frame", bus_tx, 1);
        end
        other_tx = 1'b1;
        frame(11'h123, 1'b0, '0, -1, 1'b0, '0);
        tx_req = 1'b0; repeat (2) @(negedge clk);

        // Loss at bit 10
        frame(11'h7FF, 1'b1, 11'h000, -1, 1'b0, '0);
        check(bus_tx == 1'b1 && arb_won == 1'b0, "R5 released after loss", bus_tx, 1);
        tx_req = 1'b0; repeat (2) @(negedge clk);

        // R9: identifier swapped after launch has no effect (loss at bit 8)
        frame(11'h100, 1'b1, 11'h080, -1, 1'b1, 11'h000);
        tx_req = 1'b0; repeat (2) @(negedge clk);

        // R8: bit errors in start bit and in identifier
        frame(11'h3FF, 1'b0, '0, 0, 1'b0, '0);
        check(arb_lost == 1'b0, "R8 start-bit error is not a loss", arb_lost, 0);
        frame(11'h3FF, 1'b0, '0, 1, 1'b0, '0);
        tx_req = 1'b0; repeat (4) @(negedge clk);

        check(exp_q.size() == 0, "R10 all expected outcomes seen", exp_q.size(), 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule